// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Next-Line Prefetch

This block is the instruction cache of a single-issue 32-bit processor that fetches one instruction per cycle. The fetch stage presents a physical address with a request strobe. In the same cycle the cache answers with a hit flag and the selected 32-bit instruction word. The cache holds 1 KB as 64 direct-mapped lines of 16 bytes. A missing line is refilled in a single 128-bit beat from a memory port that other requesters share. The refill runs on its own, so it carries on while the fetch stage is held by a downstream interlock.

While the memory port is otherwise idle, a hit causes the line that follows the fetched one to be loaded into a one-line prefetch buffer. A later miss on that line is served from the buffer in two cycles, where a fresh memory access costs three. The four most significant address bits take no part in the lookup, so the cache covers a 256 MB instruction space.

Top module: `ifetch_cache`

## Requirements
- R1: Address bits [31:28] are ignored. The line index is [9:4], the tag is [27:10] and the word select is [3:2]. Two addresses that differ only in [31:28] give the same hit and the same instruction.
- R2: The cache is direct mapped with 64 lines of 16 bytes. A line whose index matches a resident line but whose tag differs replaces it, so each of the two misses in turn.
- R3: On a hit, fe_instr is word w of the stored line, where w = fe_addr[3:2] and word w came from mem_rdata[32*w+31:32*w]. It is presented in the same cycle as the address.
- R4: Reset clears every line valid bit and the prefetch-buffer valid flag. The first fetch after reset misses, and no memory request is made while reset is held.
- R5: A miss that needs memory, with an immediate grant and data one cycle after the grant, keeps fe_hit low for exactly 3 cycles. The line becomes valid only when its beat arrives.
- R6: A miss on the line held in the prefetch buffer keeps fe_hit low for exactly 2 cycles and makes no memory request. The buffer is emptied once its line is copied into the cache.
- R7: A next-line prefetch (fetched line + 1) is requested only in a cycle with a hitting fetch while mem_other_req is low. It is not requested when that line is already cached or already in the buffer.
- R8: A demand refill requests the port whatever mem_other_req says. It holds mem_req only until mem_gnt, which is one cycle when the grant is immediate, and at most one request is outstanding.
- R9: A refill that has started completes while fe_req is low. Presenting the address again afterwards hits at once.
- R10: If a fetch misses on a line other than the one being prefetched while that prefetch is outstanding, the prefetched data is discarded. The miss is handled once the prefetch beat has returned, costing 4 cycles in all.
- R11: Each cycle that mem_gnt is withheld from a pending demand request adds one cycle to the miss penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fe_req | input | 1 | Fetch stage presents an address this cycle |
| fe_addr | input | 32 | Fetch physical byte address |
| fe_hit | output | 1 | Requested instruction is valid this cycle |
| fe_instr | output | 32 | Instruction word for fe_addr |
| mem_other_req | input | 1 | Another requester wants the memory port this cycle |
| mem_req | output | 1 | Cache requests a line from memory |
| mem_line_addr | output | 24 | Line address (address bits [27:4]) of the request |
| mem_gnt | input | 1 | Request accepted at this clock edge |
| mem_rvalid | input | 1 | Line beat returned this cycle |
| mem_rdata | input | 128 | Line beat, word 0 in the low 32 bits |

## Verification
The bench drives straight-line fetches that cross a line boundary, so the cost of a prefetch-buffer hit (2 cycles) can be seen apart from a fresh miss (3 cycles). It then runs the same kind of fetch with the shared port busy, which shows that prefetch waits for an idle port while demand refills do not. A branch to a distant line while a prefetch is outstanding shows the discard: the next sequential line then costs 3 cycles rather than 2. Index conflicts, aliases that differ only in the high address bits, a fetch stall during a refill and a withheld grant each bring out one address-split or timing rule. Every hit is compared against a computed memory image.

// File: rtl/ic_pkg.sv
package ic_pkg;
    localparam int IC_ADDR_W     = 32;
    localparam int IC_IGN_W      = 4;
    localparam int IC_LINE_BYTES = 16;
    localparam int IC_LINES      = 64;
    localparam int IC_WORD_W     = 32;

    localparam int IC_WPL     = IC_LINE_BYTES / (IC_WORD_W / 8);
    localparam int IC_WSEL_W  = $clog2(IC_WPL);
    localparam int IC_OFF_W   = $clog2(IC_LINE_BYTES);
    localparam int IC_IDX_W   = $clog2(IC_LINES);
    localparam int IC_PHYS_W  = IC_ADDR_W - IC_IGN_W;
    localparam int IC_LADDR_W = IC_PHYS_W - IC_OFF_W;
    localparam int IC_TAG_W   = IC_LADDR_W - IC_IDX_W;
    localparam int IC_BEAT_W  = IC_WPL * IC_WORD_W;

    typedef logic [IC_LADDR_W-1:0] line_addr_t;
    typedef logic [IC_TAG_W-1:0]   tag_t;
    typedef logic [IC_IDX_W-1:0]   idx_t;
    typedef logic [IC_WSEL_W-1:0]  wsel_t;
    typedef logic [IC_WORD_W-1:0]  word_t;
    typedef logic [IC_BEAT_W-1:0]  beat_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEMAND_REQ,
        ST_DEMAND_WAIT,
        ST_PF_WAIT,
        ST_PB_COPY
    } ic_state_e;

    function automatic line_addr_t line_of(input logic [IC_ADDR_W-1:0] a);
        return a[IC_PHYS_W-1:IC_OFF_W];
    endfunction

    function automatic wsel_t wsel_of(input logic [IC_ADDR_W-1:0] a);
        return a[IC_OFF_W-1 -: IC_WSEL_W];
    endfunction

    function automatic idx_t idx_of(input line_addr_t l);
        return l[IC_IDX_W-1:0];
    endfunction

    function automatic tag_t tag_of(input line_addr_t l);
        return l[IC_LADDR_W-1 -: IC_TAG_W];
    endfunction
endpackage

// File: rtl/ic_tag_store.sv
module ic_tag_store
    import ic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t rd_idx_a,
    output logic rd_valid_a,
    output tag_t rd_tag_a,
    input  idx_t rd_idx_b,
    output logic rd_valid_b,
    output tag_t rd_tag_b,
    input  logic wr_en,
    input  idx_t wr_idx,
    input  tag_t wr_tag
);
    logic [IC_LINES-1:0] valid_q;
    tag_t                tag_q [IC_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid_a = valid_q[rd_idx_a];
    assign rd_tag_a   = tag_q[rd_idx_a];
    assign rd_valid_b = valid_q[rd_idx_b];
    assign rd_tag_b   = tag_q[rd_idx_b];
endmodule

// File: rtl/ic_data_store.sv
module ic_data_store
    import ic_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  beat_t wr_beat,
    input  idx_t  rd_idx,
    input  wsel_t rd_wsel,
    output word_t rd_word
);
    beat_t lines_q [IC_LINES];
    beat_t rd_beat;
    word_t words [IC_WPL];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            lines_q[wr_idx] <= wr_beat;
        end
    end

    assign rd_beat = lines_q[rd_idx];

    for (genvar w = 0; w < IC_WPL; w++) begin : g_word
        assign words[w] = rd_beat[w*IC_WORD_W +: IC_WORD_W];
    end

    assign rd_word = words[rd_wsel];
endmodule

// File: rtl/ic_prefetch_buf.sv
module ic_prefetch_buf
    import ic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  line_addr_t load_line,
    input  beat_t      load_beat,
    input  logic       clear,
    output logic       pb_valid,
    output line_addr_t pb_line,
    output beat_t      pb_beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pb_valid <= 1'b0;
        end else if (load) begin
            pb_valid <= 1'b1;
        end else if (clear) begin
            pb_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            pb_line <= load_line;
            pb_beat <= load_beat;
        end
    end
endmodule

// File: rtl/ic_refill_ctrl.sv
module ic_refill_ctrl
    import ic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fe_req,
    input  line_addr_t fe_line,
    input  logic       lookup_hit,
    input  line_addr_t tgt_line,
    input  logic       tgt_present,
    input  logic       pb_valid,
    input  line_addr_t pb_line,
    input  logic       mem_other_req,
    input  logic       mem_gnt,
    input  logic       mem_rvalid,
    output logic       mem_req,
    output line_addr_t mem_line,
    output logic       arr_wr_en,
    output logic       arr_from_pb,
    output line_addr_t arr_line,
    output logic       pb_load,
    output line_addr_t pb_load_line,
    output logic       pb_clear,
    output ic_state_e  state_q,
    output line_addr_t miss_line_q
);
    ic_state_e  state_d;
    line_addr_t pf_line_q;
    logic       drop_q;
    logic       pb_match;
    logic       pf_ok;
    logic       drop_now;
    logic       fe_miss;

    assign fe_miss  = fe_req && !lookup_hit;
    assign pb_match = pb_valid && (pb_line == fe_line);
    assign pf_ok    = fe_req && lookup_hit && !mem_other_req && !tgt_present
                      && !(pb_valid && (pb_line == tgt_line));
    assign drop_now = fe_miss && (fe_line != pf_line_q);
    assign pb_load_line = pf_line_q;

    always_comb begin
        state_d     = state_q;
        mem_req     = 1'b0;
        mem_line    = tgt_line;
        arr_wr_en   = 1'b0;
        arr_from_pb = 1'b0;
        arr_line    = miss_line_q;
        pb_load     = 1'b0;
        pb_clear    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fe_miss) begin
                    state_d = pb_match ? ST_PB_COPY : ST_DEMAND_REQ;
                end else if (pf_ok) begin
                    mem_req = 1'b1;
                    if (mem_gnt) state_d = ST_PF_WAIT;
                end
            end
            ST_DEMAND_REQ: begin
                mem_req  = 1'b1;
                mem_line = miss_line_q;
                if (mem_gnt) state_d = ST_DEMAND_WAIT;
            end
            ST_DEMAND_WAIT: begin
                if (mem_rvalid) begin
                    arr_wr_en = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_PF_WAIT: begin
                if (mem_rvalid) begin
                    pb_load = !(drop_q || drop_now);
                    state_d = ST_IDLE;
                end
            end
            ST_PB_COPY: begin
                arr_wr_en   = 1'b1;
                arr_from_pb = 1'b1;
                arr_line    = pb_line;
                pb_clear    = 1'b1;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            drop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PF_WAIT && !mem_rvalid && drop_now) begin
                drop_q <= 1'b1;
            end else if (state_d != ST_PF_WAIT) begin
                drop_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && fe_miss && !pb_match) begin
            miss_line_q <= fe_line;
        end
        if (state_q == ST_IDLE && !fe_miss && pf_ok && mem_gnt) begin
            pf_line_q <= tgt_line;
        end
    end
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
    import ic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fe_req,
    input  logic [31:0] fe_addr,
    output logic        fe_hit,
    output logic [31:0] fe_instr,
    input  logic        mem_other_req,
    output logic        mem_req,
    output logic [23:0] mem_line_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [127:0] mem_rdata
);
    line_addr_t fe_line;
    line_addr_t tgt_line;
    logic       valid_a, valid_b;
    tag_t       tag_a, tag_b;
    logic       tgt_present;
    logic       arr_wr_en, arr_from_pb;
    line_addr_t arr_line;
    beat_t      arr_beat;
    logic       pb_load, pb_clear, pb_valid;
    line_addr_t pb_line, pb_load_line;
    beat_t      pb_beat;
    ic_state_e  ctrl_state;
    line_addr_t miss_line;
    logic       unused_addr_bits;

    assign unused_addr_bits = ^{fe_addr[IC_ADDR_W-1 -: IC_IGN_W], fe_addr[1:0]};

    assign fe_line  = line_of(fe_addr);
    assign tgt_line = line_addr_t'(fe_line + 1'b1);

    ic_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .rd_idx_a   (idx_of(fe_line)),
        .rd_valid_a (valid_a),
        .rd_tag_a   (tag_a),
        .rd_idx_b   (idx_of(tgt_line)),
        .rd_valid_b (valid_b),
        .rd_tag_b   (tag_b),
        .wr_en      (arr_wr_en),
        .wr_idx     (idx_of(arr_line)),
        .wr_tag     (tag_of(arr_line))
    );

    assign fe_hit      = fe_req && valid_a && (tag_a == tag_of(fe_line));
    assign tgt_present = valid_b && (tag_b == tag_of(tgt_line));
    assign arr_beat    = arr_from_pb ? pb_beat : mem_rdata;

    ic_data_store u_data (
        .clk     (clk),
        .wr_en   (arr_wr_en),
        .wr_idx  (idx_of(arr_line)),
        .wr_beat (arr_beat),
        .rd_idx  (idx_of(fe_line)),
        .rd_wsel (wsel_of(fe_addr)),
        .rd_word (fe_instr)
    );

    ic_prefetch_buf u_pbuf (
        .clk       (clk),
        .rst       (rst),
        .load      (pb_load),
        .load_line (pb_load_line),
        .load_beat (mem_rdata),
        .clear     (pb_clear),
        .pb_valid  (pb_valid),
        .pb_line   (pb_line),
        .pb_beat   (pb_beat)
    );

    ic_refill_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .fe_req        (fe_req),
        .fe_line       (fe_line),
        .lookup_hit    (fe_hit),
        .tgt_line      (tgt_line),
        .tgt_present   (tgt_present),
        .pb_valid      (pb_valid),
        .pb_line       (pb_line),
        .mem_other_req (mem_other_req),
        .mem_gnt       (mem_gnt),
        .mem_rvalid    (mem_rvalid),
        .mem_req       (mem_req),
        .mem_line      (mem_line_addr),
        .arr_wr_en     (arr_wr_en),
        .arr_from_pb   (arr_from_pb),
        .arr_line      (arr_line),
        .pb_load       (pb_load),
        .pb_load_line  (pb_load_line),
        .pb_clear      (pb_clear),
        .state_q       (ctrl_state),
        .miss_line_q   (miss_line)
    );
endmodule

// File: rtl/ic_checker.sv
module ic_checker
    import ic_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        fe_req,
    input logic [31:0] fe_addr,
    input logic        fe_hit,
    input logic        mem_other_req,
    input logic        mem_req,
    input logic        mem_gnt,
    input logic        mem_rvalid,
    input ic_state_e   st,
    input line_addr_t  miss_line,
    input logic        pb_valid,
    input line_addr_t  pb_line
);
    // R4: nothing is resident in the first cycle after reset
    a_r4_cold_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !fe_hit);

    // R5: a demand beat makes the held address hit next cycle
    a_r5_fill_then_hit: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEMAND_WAIT && mem_rvalid && fe_req && fe_addr[27:4] == miss_line)
        ##1 (fe_req && $stable(fe_addr)) |-> fe_hit);

    // R6: the buffer copy makes the held address hit next cycle
    a_r6_copy_then_hit: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PB_COPY && fe_req && fe_addr[27:4] == pb_line)
        ##1 (fe_req && $stable(fe_addr)) |-> fe_hit);

    // R6: buffer is empty after its line moved into the cache
    a_r6_buf_emptied: assert property (@(posedge clk) disable iff (rst)
        st == ST_PB_COPY |=> !pb_valid);

    // R7: with the port busy elsewhere only a demand refill requests
    a_r7_pf_idle_port: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_other_req) |-> st == ST_DEMAND_REQ);

    // R8: one request outstanding, one port cycle per grant
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> !mem_req);
endmodule

bind ifetch_cache ic_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .fe_req        (fe_req),
    .fe_addr       (fe_addr),
    .fe_hit        (fe_hit),
    .mem_other_req (mem_other_req),
    .mem_req       (mem_req),
    .mem_gnt       (mem_gnt),
    .mem_rvalid    (mem_rvalid),
    .st            (ctrl_state),
    .miss_line     (miss_line),
    .pb_valid      (pb_valid),
    .pb_line       (pb_line)
);

// File: tb/ifetch_cache_tb.sv
module ifetch_cache_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fe_req = 1'b0;
    logic [31:0]  fe_addr = '0;
    logic         fe_hit;
    logic [31:0]  fe_instr;
    logic         mem_other_req = 1'b0;
    logic         mem_req;
    logic [23:0]  mem_line_addr;
    logic         mem_gnt = 1'b1;
    logic         mem_rvalid = 1'b0;
    logic [127:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int gnt_block = 0;
    logic oreq_set = 1'b0;
    logic pend = 1'b0;
    logic [23:0] pend_line = '0;
    int mreq_cnt = 0;
    logic last_mreq = 1'b0;
    bit delivered [int];

    always #5 clk = ~clk;

    ifetch_cache u_dut (
        .clk(clk), .rst(rst), .fe_req(fe_req), .fe_addr(fe_addr),
        .fe_hit(fe_hit), .fe_instr(fe_instr), .mem_other_req(mem_other_req),
        .mem_req(mem_req), .mem_line_addr(mem_line_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] word_of(input logic [23:0] l, input int w);
        logic [31:0] k;
        k = {6'd0, l, 2'(w)};
        return 32'h5A00_0000 ^ (k * 32'h9E37_79B1);
    endfunction

    function automatic logic [127:0] beat_of(input logic [23:0] l);
        logic [127:0] b;
        for (int w = 0; w < 4; w++) b[w*32 +: 32] = word_of(l, w);
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one clock: respond to memory, apply inputs, sample away from the edge
    task automatic step(input logic req, input logic [31:0] addr);
        @(negedge clk);
        mem_rvalid = pend;
        mem_rdata  = pend ? beat_of(pend_line) : '0;
        if (pend) delivered[int'(pend_line)] = 1'b1;
        pend = 1'b0;
        mem_gnt = (gnt_block > 0) ? 1'b0 : 1'b1;
        if (gnt_block > 0) gnt_block--;
        mem_other_req = oreq_set;
        fe_req  = req;
        fe_addr = addr;
        #1;
        if (fe_hit) begin
            check(fe_instr == word_of(addr[27:4], int'(addr[3:2])), "R3",
                  "instruction", fe_instr, word_of(addr[27:4], int'(addr[3:2])));
            check(delivered.exists(int'(addr[27:4])), "R5", "hit before beat",
                  0, 1);
        end
        last_mreq = mem_req;
        if (mem_req) mreq_cnt++;
        if (mem_req && mem_gnt) begin
            pend = 1'b1;
            pend_line = mem_line_addr;
        end
    endtask

    task automatic fetch(input logic [31:0] addr, output int n, output int mq);
        n = 0;
        mreq_cnt = 0;
        for (int i = 0; i < 30; i++) begin
            step(1'b1, addr);
            if (fe_hit) break;
            n++;
        end
        mq = mreq_cnt;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    localparam logic [31:0] A_ADDR = 32'h0000_0100;
    localparam logic [31:0] B_ADDR = 32'h0000_2340;
    localparam logic [31:0] D_ADDR = 32'h0000_5670;
    localparam logic [31:0] E_ADDR = 32'h0000_0500;
    localparam logic [31:0] G_ADDR = 32'h0000_0880;

    initial begin
        int n;
        int mq;
        for (int i = 0; i < 3; i++) step(1'b0, 32'h0);
        check(mem_req == 1'b0, "R4", "mem_req in reset", mem_req, 0);
        check(fe_hit == 1'b0, "R4", "hit in reset", fe_hit, 0);
        @(negedge clk);
        rst = 1'b0;

        // R4 R5: cold cache, fresh miss
        fetch(A_ADDR, n, mq);
        check(n == 3, "R5", "fresh miss penalty", n, 3);
        check(mq == 2, "R7", "demand plus next-line prefetch", mq, 2);
        for (int w = 1; w < 4; w++) begin
            step(1'b1, A_ADDR + 32'(4*w));
            check(fe_hit == 1'b1, "R3", "sequential word hit", fe_hit, 1);
        end

        // R6: next line served from the prefetch buffer, port now busy
        oreq_set = 1'b1;
        fetch(A_ADDR + 32'h10, n, mq);
        check(n == 2, "R6", "buffer miss penalty", n, 2);
        check(mq == 0, "R6", "memory requests on buffer miss", mq, 0);
        mreq_cnt = 0;
        for (int w = 1; w < 4; w++) step(1'b1, A_ADDR + 32'h10 + 32'(4*w));
        check(mreq_cnt == 0, "R7", "prefetch while port busy", mreq_cnt, 0);

        // R8: demand refill ignores other requester and takes one port cycle
        fetch(A_ADDR + 32'h20, n, mq);
        check(n == 3, "R8", "demand miss with port busy", n, 3);
        check(mq == 1, "R8", "port cycles for one refill", mq, 1);

        // R9: refill completes while fetch is stalled
        step(1'b1, B_ADDR);
        for (int i = 0; i < 5; i++) step(1'b0, 32'h0);
        fetch(B_ADDR, n, mq);
        check(n == 0, "R9", "hit after stalled refill", n, 0);

        // R11: withheld grant lengthens the miss
        gnt_block = 3;
        fetch(G_ADDR, n, mq);
        check(n == 5, "R11", "miss penalty with 2 withheld grants", n, 5);

        // R2: same index, different tag evicts
        fetch(E_ADDR, n, mq);
        check(n == 3, "R2", "conflicting line miss", n, 3);
        fetch(A_ADDR, n, mq);
        check(n == 3, "R2", "evicted line misses again", n, 3);

        // R1: high address bits ignored
        fetch(32'hF000_0000 | A_ADDR | 32'h8, n, mq);
        check(n == 0, "R1", "alias in bits 31:28 hits", n, 0);

        // R7 R10: prefetch on idle port, then branch away discards it
        oreq_set = 1'b0;
        step(1'b1, B_ADDR);
        check(last_mreq == 1'b1, "R7", "prefetch on idle port", last_mreq, 1);
        oreq_set = 1'b1;
        fetch(D_ADDR, n, mq);
        check(n == 4, "R10", "miss behind outstanding prefetch", n, 4);
        fetch(B_ADDR + 32'h10, n, mq);
        check(n == 3, "R10", "discarded prefetch not used", n, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule